// File: doc/BRIEF.md
# Multi-Lane Tagged SPI Master

This block is an SPI master that moves one, two or four bits per shift-clock period, so the same engine can drive a standard single-line slave or a dual- or quad-line memory. Software writes each data word into one of 32 addresses. The address offset (0 to 31) becomes a 5-bit tag that travels with that word. Depending on the tag usage setting, the tag either carries the word length and an end-of-frame marker, or drives five of the eight active-low chip selects directly.

A frame is one stretch during which chip select is held low. It either has a fixed bit count of up to 63 bits, or is open-ended. An open frame closes after a word marked as last has been shifted. A single holding register sits in front of the shifter, so the next word can be queued while the current one is moving. An optional gating input holds a queued word back until an external trigger is high. Each finished word is returned on a received-word output with a one-cycle valid pulse.

The controller has five states:

- **S_IDLE** waits for a queued word. Chip select may still be held if an open frame continues.
- **S_LEAD** is the chip-select setup half period before the first clock of a frame.
- **S_LOW** is the half period with SCLK low, during which the output bits are set up.
- **S_HIGH** is the half period with SCLK high.
- **S_GAP** holds chip select high for one half period after a frame ends.

The transitions are:

- IDLE→LEAD: a word starts and no frame is open.
- IDLE→LOW: a word starts inside an open frame.
- LEAD→LOW and LOW→HIGH: the half period expires. The inputs are sampled on LOW→HIGH.
- HIGH→LOW: the word continues. The outputs shift here.
- HIGH→IDLE: the word is done but the frame is not.
- HIGH→GAP: the frame ends.
- GAP→LEAD: the frame ended mid-word and the rest of the word is still to shift.
- GAP→IDLE: nothing of the current word is left.

Top module: `qspi_tag_master`

## Requirements
- R1: After reset, `ss_n` is 8'hFF, `sclk` is 0, `rx_valid` is 0 and `wr_ready` is 1.
- R2: A word is taken when `wr_valid` and `wr_ready` are both high, and its tag is `wr_addr`. `wr_ready` is low while a word waits in the holding register. The holding register empties when that word starts shifting.
- R3: When `cfg_tag_sel`=0, the word length is tag[3:0]+1 bits, taken from the low bits of `wr_data` and sent MSB first. For example, tag 5'h07 sends 8 bits.
- R4: `cfg_lanes` selects the lane mode: 0 is one lane, 1 is two lanes, 2 is four lanes.
  - One lane: output on `io_out[0]`, input on `io_in[1]`.
  - Two lanes: `io[1]` carries the higher bit of each pair.
  - Four lanes: `io[3]` carries the highest bit of each nibble.
  - A word takes ceil(length/lanes) clocks. The missing low bits are sent as zeros.
  - `rx_data` is the first length bits received, right-aligned.
- R5: SCLK idles low and has a period of 2*(`cfg_div`+1) system clocks. Outputs change at the falling edge and inputs are sampled at the rising edge.
- R6: In open-frame mode (`cfg_frame_fixed`=0) with `cfg_tag_sel`=0, `ss_n` is 8'hFE from the start of the frame. It stays low between words and goes high only after a word with tag bit 4 set has been fully shifted.
- R7: In fixed-frame mode, `ss_n` goes high after `cfg_frame_len` bits (clocks times lanes), even in the middle of a word. It stays high for one half period, then a new frame resumes the same word. Tag bit 4 is ignored in this mode.
- R8: When `cfg_tag_sel`=1, `ss_n[4:0]` is the inverse of the tag and `ss_n[7:5]` stays high. For example, tag 5'b01111 gives 8'hF0. The word length is `cfg_wlen`+1, and an open frame ends after every word.
- R9: When `cfg_gate`=1, a queued word produces no SCLK and no chip select while `trig` is low.
- R10: The output enables `io_oe` follow the lane mode and the input setting:

  | Lane mode | `cfg_lane_in` | `io_oe` |
  |---|---|---|
  | one lane | any | 4'b0001 |
  | two lanes | 0 | 4'b0011 |
  | four lanes | 0 | 4'b1111 |
  | two or four lanes | 1 | 4'b0000 |

- R11: Each completed word produces exactly one `rx_valid` pulse, one cycle long, carrying its received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Holding register free |
| wr_addr | input | 5 | Window offset, becomes the tag |
| wr_data | input | 16 | Word to send, LSB-aligned |
| cfg_lanes | input | 2 | Lane mode: 0 one lane, 1 two lanes, 2 four lanes |
| cfg_tag_sel | input | 1 | 0 tag gives length and end of frame; 1 tag drives selects |
| cfg_wlen | input | 4 | Word length minus one, used when cfg_tag_sel=1 |
| cfg_frame_fixed | input | 1 | 1 selects the fixed bit-count frame |
| cfg_frame_len | input | 6 | Fixed frame length in bits |
| cfg_gate | input | 1 | Hold queued words until trig is high |
| cfg_div | input | 10 | Half period minus one, in system clocks |
| cfg_lane_in | input | 1 | Multi-lane pins act as inputs |
| trig | input | 1 | Transfer trigger |
| sclk | output | 1 | Shift clock |
| ss_n | output | 8 | Active-low chip selects |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | 16 | Received word, right-aligned |

## Verification
The bench targets the following corner cases:

- **Word lengths that do not fill the last lane step**, for example 5 bits over four lanes. A design that pads at the wrong end, or keeps the pad bits when it receives, shows a wrong pattern on the lines or a shifted `rx_data`.
- **A fixed frame that ends in the middle of a word.** If the word is dropped or restarted instead of resumed, the chip-select spans come out other than 12 and 12, or the captured stream changes.
- **An open frame spread over two words.** A design that releases chip select early splits the span.
- **A gated word held back for a long time.** A design that ignores `trig` produces clock edges while the trigger is low.

// File: rtl/qtm_pkg.sv
package qtm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_LOW,
        S_HIGH,
        S_GAP
    } qtm_state_e;

    // log2 of the lane count; code 3 is treated as four lanes
    function automatic logic [1:0] lane_log2(input logic [1:0] code);
        return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/qtm_tag_decode.sv
module qtm_tag_decode #(
    parameter int TAG_W = 5,
    parameter int SEL_W = 8,
    parameter int LEN_W = 5
) (
    input  logic [TAG_W-1:0] tag,
    input  logic             cfg_tag_sel,
    input  logic [3:0]       cfg_wlen,
    output logic [LEN_W-1:0] word_len,
    output logic             eof,
    output logic [SEL_W-1:0] sel
);
    always_comb begin
        if (cfg_tag_sel) begin
            word_len = LEN_W'(cfg_wlen) + LEN_W'(1);
            eof      = 1'b1;
            sel      = SEL_W'(tag);
        end else begin
            word_len = LEN_W'(tag[3:0]) + LEN_W'(1);
            eof      = tag[TAG_W-1];
            sel      = SEL_W'(1);
        end
    end
endmodule

// File: rtl/qtm_lane_shift.sv
module qtm_lane_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    input  logic              sample,
    input  logic [1:0]        lsh,
    input  logic [3:0]        io_in,
    output logic [3:0]        io_out,
    output logic [DATA_W-1:0] rx_raw
);
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= load_data;
            rx_q <= '0;
        end else begin
            if (shift) begin
                unique case (lsh)
                    2'd0:    tx_q <= {tx_q[DATA_W-2:0], 1'b0};
                    2'd1:    tx_q <= {tx_q[DATA_W-3:0], 2'b00};
                    default: tx_q <= {tx_q[DATA_W-5:0], 4'b0000};
                endcase
            end
            if (sample) begin
                unique case (lsh)
                    2'd0:    rx_q <= {rx_q[DATA_W-2:0], io_in[1]};
                    2'd1:    rx_q <= {rx_q[DATA_W-3:0], io_in[1:0]};
                    default: rx_q <= {rx_q[DATA_W-5:0], io_in[3:0]};
                endcase
            end
        end
    end

    always_comb begin
        unique case (lsh)
            2'd0:    io_out = {3'b000, tx_q[DATA_W-1]};
            2'd1:    io_out = {2'b00, tx_q[DATA_W-1 -: 2]};
            default: io_out = tx_q[DATA_W-1 -: 4];
        endcase
    end

    assign rx_raw = rx_q;

    // R4: shift and sample never land on the same cycle as a load
    a_r4_load_alone: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !(shift || sample));
endmodule

// File: rtl/qspi_tag_master.sv
module qspi_tag_master
    import qtm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 10,
    parameter int SEL_W  = 8,
    parameter int FLEN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [4:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cfg_lanes,
    input  logic              cfg_tag_sel,
    input  logic [3:0]        cfg_wlen,
    input  logic              cfg_frame_fixed,
    input  logic [FLEN_W-1:0] cfg_frame_len,
    input  logic              cfg_gate,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_lane_in,
    input  logic              trig,
    output logic              sclk,
    output logic [SEL_W-1:0]  ss_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data
);
    localparam int TAG_W = 5;
    localparam int LEN_W = $clog2(DATA_W) + 1;
    localparam int FB_W  = FLEN_W + 1;

    qtm_state_e state, nxt;

    logic [DIV_W-1:0]  cnt;
    logic              hold_vld;
    logic [DATA_W-1:0] hold_data;
    logic [TAG_W-1:0]  hold_tag;
    logic              in_frame;
    logic [SEL_W-1:0]  sel_q;
    logic [LEN_W-1:0]  steps_left;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  pad_q;
    logic              eof_q;
    logic [FB_W-1:0]   frame_bits;

    logic [LEN_W-1:0]  dec_len;
    logic              dec_eof;
    logic [SEL_W-1:0]  dec_sel;
    logic [1:0]        lsh;
    logic [LEN_W:0]    lanes_n;
    logic [LEN_W-1:0]  steps_c;
    logic [LEN_W-1:0]  pad_c;
    logic [DATA_W-1:0] load_data;
    logic [DATA_W-1:0] rx_raw;
    logic [FB_W-1:0]   fb_next;
    logic              half_done, start, word_done, frame_end;
    logic              do_shift, do_sample;

    qtm_tag_decode #(.TAG_W(TAG_W), .SEL_W(SEL_W), .LEN_W(LEN_W)) u_dec (
        .tag        (hold_tag),
        .cfg_tag_sel(cfg_tag_sel),
        .cfg_wlen   (cfg_wlen),
        .word_len   (dec_len),
        .eof        (dec_eof),
        .sel        (dec_sel)
    );

    assign lsh       = lane_log2(cfg_lanes);
    assign lanes_n   = (LEN_W+1)'(1) << lsh;
    assign steps_c   = LEN_W'(({1'b0, dec_len} + lanes_n - (LEN_W+1)'(1)) >> lsh);
    assign pad_c     = LEN_W'(({1'b0, steps_c} << lsh) - {1'b0, dec_len});
    assign load_data = hold_data << (DATA_W - 32'(dec_len));

    assign half_done = (cnt == '0);
    assign start     = (state == S_IDLE) && hold_vld && (!cfg_gate || trig);
    assign word_done = (steps_left == LEN_W'(1));
    assign fb_next   = frame_bits + FB_W'(lanes_n);
    assign frame_end = cfg_frame_fixed ? (fb_next >= FB_W'(cfg_frame_len))
                                       : (word_done && eof_q);
    assign do_sample = (state == S_LOW)  && half_done;
    assign do_shift  = (state == S_HIGH) && half_done;
    assign wr_ready  = !hold_vld;

    qtm_lane_shift #(.DATA_W(DATA_W)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_data(load_data),
        .shift    (do_shift),
        .sample   (do_sample),
        .lsh      (lsh),
        .io_in    (io_in),
        .io_out   (io_out),
        .rx_raw   (rx_raw)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start)     nxt = in_frame ? S_LOW : S_LEAD;
            S_LEAD: if (half_done) nxt = S_LOW;
            S_LOW:  if (half_done) nxt = S_HIGH;
            S_HIGH: if (half_done) nxt = frame_end ? S_GAP :
                                         word_done ? S_IDLE : S_LOW;
            S_GAP:  if (half_done) nxt = (steps_left != '0) ? S_LEAD : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            hold_vld   <= 1'b0;
            hold_data  <= '0;
            hold_tag   <= '0;
            in_frame   <= 1'b0;
            sel_q      <= '0;
            steps_left <= '0;
            len_q      <= '0;
            pad_q      <= '0;
            eof_q      <= 1'b0;
            frame_bits <= '0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (nxt != state)       cnt <= cfg_div;
            else if (cnt != '0)     cnt <= cnt - DIV_W'(1);

            if (wr_valid && wr_ready) begin
                hold_vld  <= 1'b1;
                hold_data <= wr_data;
                hold_tag  <= wr_addr;
            end else if (start) begin
                hold_vld  <= 1'b0;
            end

            if (start) begin
                len_q      <= dec_len;
                eof_q      <= dec_eof;
                pad_q      <= pad_c;
                steps_left <= steps_c;
                if (!in_frame) begin
                    in_frame   <= 1'b1;
                    sel_q      <= dec_sel;
                    frame_bits <= '0;
                end
            end

            if (do_shift) begin
                steps_left <= steps_left - LEN_W'(1);
                frame_bits <= fb_next;
                if (word_done) begin
                    rx_valid <= 1'b1;
                    rx_data  <= rx_raw >> pad_q;
                end
                if (frame_end) in_frame <= 1'b0;
            end

            if ((state == S_GAP) && half_done && (steps_left != '0)) begin
                in_frame   <= 1'b1;
                frame_bits <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        sclk = (state == S_HIGH);
        ss_n = in_frame ? ~sel_q : '1;
        if (lsh == 2'd0)      io_oe = 4'b0001;
        else if (cfg_lane_in) io_oe = 4'b0000;
        else if (lsh == 2'd1) io_oe = 4'b0011;
        else                  io_oe = 4'b1111;
    end

    // R2: an accepted word blocks the next one until it starts
    a_r2_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);
    // R5: lane outputs hold still while SCLK is high
    a_r5_io_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HIGH && $past(state) == S_HIGH) |-> $stable(io_out));
    // R5: no clock pulse outside a frame
    a_r5_clock_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> in_frame);
    // R9: a gated word does not start while the trigger is low
    a_r9_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && hold_vld && cfg_gate && !trig) |=> (state == S_IDLE && hold_vld));
    // R11: received word fits its length, strobe is a single cycle
    a_r11_rx_width: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> len_q) == '0));
    a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: tb/qspi_tag_master_test.sv
module qspi_tag_master_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  cfg_lanes = 2'd0;
    logic        cfg_tag_sel = 1'b0;
    logic [3:0]  cfg_wlen = 4'd7;
    logic        cfg_frame_fixed = 1'b0;
    logic [5:0]  cfg_frame_len = 6'd8;
    logic        cfg_gate = 1'b0;
    logic [9:0]  cfg_div = 10'd1;
    logic        cfg_lane_in = 1'b0;
    logic        trig = 1'b0;
    logic        sclk;
    logic [7:0]  ss_n;
    logic [3:0]  io_out, io_oe, io_in;
    logic        rx_valid;
    logic [15:0] rx_data;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    qspi_tag_master uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .cfg_lanes(cfg_lanes),
        .cfg_tag_sel(cfg_tag_sel), .cfg_wlen(cfg_wlen),
        .cfg_frame_fixed(cfg_frame_fixed), .cfg_frame_len(cfg_frame_len),
        .cfg_gate(cfg_gate), .cfg_div(cfg_div), .cfg_lane_in(cfg_lane_in),
        .trig(trig), .sclk(sclk), .ss_n(ss_n), .io_out(io_out), .io_oe(io_oe),
        .io_in(io_in), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    int          lanes_n;
    logic [31:0] cap;
    logic [31:0] svec;
    int          rise, span_cnt, n_spans, n_rx;
    int          spans [8];
    logic [15:0] rx_log [8];
    logic [7:0]  seen_ss;
    longint      cyc = 0, last_rise = 0, rise_gap = 0;

    assign lanes_n = (cfg_lanes == 2'd0) ? 1 : (cfg_lanes == 2'd1) ? 2 : 4;

    always_comb begin
        unique case (lanes_n)
            1:       io_in = {2'b00, svec[31], 1'b0};
            2:       io_in = {2'b00, svec[31:30]};
            default: io_in = svec[31:28];
        endcase
    end

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge sclk) begin
        if (rise == 0) seen_ss = ss_n;
        unique case (lanes_n)
            1:       cap = (cap << 1) | 32'(io_out[0]);
            2:       cap = (cap << 2) | 32'(io_out[1:0]);
            default: cap = (cap << 4) | 32'(io_out);
        endcase
        rise = rise + 1;
        span_cnt = span_cnt + 1;
        rise_gap = cyc - last_rise;
        last_rise = cyc;
    end

    always @(negedge sclk) svec = svec << lanes_n;

    always @(negedge (&ss_n)) span_cnt = 0;
    always @(posedge (&ss_n)) begin
        if (n_spans < 8) spans[n_spans] = span_cnt;
        n_spans = n_spans + 1;
    end

    always @(posedge clk) begin
        if (rst_n && rx_valid) begin
            if (n_rx < 8) rx_log[n_rx] <= rx_data;
            n_rx <= n_rx + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        while (n_rx < n) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    task automatic clear_mon(input logic [31:0] sv);
        cap = '0; rise = 0; n_spans = 0; n_rx = 0; svec = sv;
    endtask

    function automatic int steps_of(input int len, input int ln);
        return (len + ln - 1) / ln;
    endfunction

    function automatic logic [31:0] exp_cap(input logic [15:0] d, input int len, input int ln);
        logic [31:0] m;
        m = 32'(d) & ((32'd1 << len) - 1);
        return m << (steps_of(len, ln) * ln - len);
    endfunction

    function automatic logic [15:0] exp_rx(input logic [31:0] sv, input int len);
        return 16'(sv >> (32 - len));
    endfunction

    initial begin
        void'($urandom(32'd4242));
        clear_mon('0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        clear_mon('0);
        // R1 reset state
        chk("R1 ss_n", 32'(ss_n), 32'hFF);
        chk("R1 sclk", 32'(sclk), 32'h0);
        chk("R1 rx_valid", 32'(rx_valid), 32'h0);
        chk("R1 wr_ready", 32'(wr_ready), 32'h1);

        // R10 output enables
        cfg_lanes = 2'd0; #1; chk("R10 oe single", 32'(io_oe), 32'h1);
        cfg_lanes = 2'd1; #1; chk("R10 oe dual out", 32'(io_oe), 32'h3);
        cfg_lanes = 2'd2; #1; chk("R10 oe quad out", 32'(io_oe), 32'hF);
        cfg_lane_in = 1'b1; #1; chk("R10 oe quad in", 32'(io_oe), 32'h0);
        cfg_lane_in = 1'b0;

        // R4 padding: 5 bits over four lanes
        cfg_lanes = 2'd2; cfg_div = 10'd1;
        clear_mon(32'hC8000000);
        put(5'h14, 16'h0016);
        wait_rx(1);
        chk("R4 quad pad tx", cap, 32'hB0);
        chk("R4 quad steps", 32'(rise), 32'd2);
        chk("R4 quad pad rx", 32'(rx_log[0]), 32'h19);

        // R5 divider
        cfg_lanes = 2'd0; cfg_div = 10'd9;
        clear_mon(32'hA0000000);
        put(5'h13, 16'h0009);
        wait_rx(1);
        chk("R5 sclk period", 32'(rise_gap), 32'd20);
        chk("R3 msb first", cap, 32'h9);
        cfg_div = 10'd1;

        // R8 select mode
        cfg_tag_sel = 1'b1; cfg_wlen = 4'd7;
        clear_mon(32'h5A000000);
        put(5'b01111, 16'h00A5);
        wait_rx(1);
        chk("R8 selects", 32'(seen_ss), 32'hF0);
        chk("R8 tx", cap, 32'hA5);
        chk("R8 rx", 32'(rx_log[0]), 32'h5A);
        chk("R8 one frame", 32'(n_spans), 32'd1);
        chk("R8 span", 32'(spans[0]), 32'd8);
        cfg_tag_sel = 1'b0;

        // R6 open frame over two words
        clear_mon(32'h12000000);
        put(5'h07, 16'h003C);
        wait_rx(1);
        chk("R6 held between words", 32'(ss_n), 32'hFE);
        svec = 32'h34000000;
        put(5'h17, 16'h00C3);
        wait_rx(2);
        chk("R6 one span", 32'(n_spans), 32'd1);
        chk("R6 span len", 32'(spans[0]), 32'd16);
        chk("R6 tx stream", cap, 32'h3CC3);
        chk("R11 rx count", 32'(n_rx), 32'd2);
        chk("R11 rx second", 32'(rx_log[1]), 32'h34);

        // R7 fixed frame of 12 bits across three 8-bit words
        cfg_frame_fixed = 1'b1; cfg_frame_len = 6'd12;
        clear_mon(32'h9ABCDE00);
        put(5'h17, 16'h0011);
        put(5'h07, 16'h0022);
        chk("R2 ready low while held", 32'(wr_ready), 32'h0);
        put(5'h07, 16'h0033);
        wait_rx(3);
        chk("R7 spans", 32'(n_spans), 32'd2);
        chk("R7 span one", 32'(spans[0]), 32'd12);
        chk("R7 span two", 32'(spans[1]), 32'd12);
        chk("R7 stream", cap & 32'hFFFFFF, 32'h112233);
        chk("R7 rx mid", 32'(rx_log[1]), 32'hBC);
        chk("R7 rx last", 32'(rx_log[2]), 32'hDE);
        cfg_frame_fixed = 1'b0;

        // R9 gating
        cfg_gate = 1'b1; trig = 1'b0;
        clear_mon(32'hF0000000);
        put(5'h17, 16'h0081);
        repeat (200) @(negedge clk);
        chk("R9 no clock", 32'(rise), 32'd0);
        chk("R9 no select", 32'(ss_n), 32'hFF);
        trig = 1'b1;
        wait_rx(1);
        chk("R9 released rx", 32'(rx_log[0]), 32'hF0);
        chk("R9 released tx", cap, 32'h81);
        trig = 1'b0; cfg_gate = 1'b0;

        // random words, one per frame
        for (int i = 0; i < 40; i++) begin
            logic [15:0] d;
            logic [31:0] sv;
            int len, ln;
            logic [3:0] t;
            cfg_lanes = 2'($urandom_range(0, 2));
            cfg_div = 10'($urandom_range(0, 3));
            t = 4'($urandom_range(0, 15));
            d = 16'($urandom);
            sv = $urandom;
            len = int'(t) + 1;
            ln = (cfg_lanes == 2'd0) ? 1 : (cfg_lanes == 2'd1) ? 2 : 4;
            clear_mon(sv);
            put({1'b1, t}, d);
            wait_rx(1);
            chk("R3 R4 tx", cap, exp_cap(d, len, ln));
            chk("R4 rx", 32'(rx_log[0]), 32'(exp_rx(sv, len)));
            chk("R4 steps", 32'(rise), 32'(steps_of(len, ln)));
            chk("R6 select", 32'(seen_ss), 32'hFE);
            if (rise > 1) chk("R5 period", 32'(rise_gap), 32'(2 * (int'(cfg_div) + 1)));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule